// File: doc/BRIEF.md
# Serial Line Transmitter with Idle Preamble

This block turns bytes from a valid/ready source into asynchronous serial characters on a single output line. The character format is chosen at run time: five to eight data bits, an optional parity bit of selectable sense, and one or two stop bits. A shared one-cycle baud strobe paces every bit. The block produces no baud rate of its own.

Bytes arrive in groups called buffers. The first byte of a buffer is marked by a first-byte flag, and it may also carry a preamble request. When the request is present, the transmitter first holds the line high for exactly one character time of the current format. It then sends that byte's character. Later bytes of the same buffer ignore the preamble request. When one character ends and another byte is already waiting, the next start bit follows the last stop bit with no idle time between them, even across a buffer boundary. A character that has begun always runs to its end; the block has no error or abort path.

Top module: `uart_pre_tx`

## Requirements
- R1: After a synchronous active-low reset, `tx_line` is 1 and `busy` is 0.
- R2: A character is a 0 start bit, then N data bits least significant first, where N = 5 + `cfg_len_code` (codes 0..3 give 5..8), then the parity bit when enabled, then one stop bit of value 1, or two when `cfg_stop2` is 1.
- R3: With `cfg_par_en` = 1, the parity bit is computed over the N data bits only: even parity (data plus parity hold an even number of ones) when `cfg_par_odd` = 0, odd parity when it is 1.
- R4: Every character occupies exactly 1 + N + P + S baud intervals, where P is 1 with parity enabled (else 0) and S is the number of stop bits.
- R5: A byte with `in_first` = 1 and `in_pre` = 1 is preceded by a run of ones lasting exactly the R4 character length of the current format. Its start bit begins on the baud tick that ends that run.
- R6: No preamble is sent for a byte with `in_pre` = 0, or for a byte with `in_first` = 0 whatever its `in_pre` value.
- R7: When a byte is valid at the tick that ends the last stop bit, its start bit (or its preamble) begins at that tick, with no idle interval in between.
- R8: When no character or preamble is in progress, `tx_line` is 1 and `busy` is 0.
- R9: `tx_line` changes only on the clock edge that samples `baud_tick` high, so each bit lasts one baud interval.
- R10: `in_ready` is high only in a cycle where `baud_tick` is high and the line is idle or in the last bit of a frame. It stays low for a byte whose preamble has not yet been sent. Once started, a frame runs to completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | One-cycle strobe marking each bit boundary |
| cfg_len_code | input | 2 | Data bit count minus five |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 even |
| cfg_stop2 | input | 1 | 1 selects two stop bits |
| in_valid | input | 1 | A byte is offered |
| in_data | input | 8 | Byte to send, low bits used for short formats |
| in_first | input | 1 | Offered byte opens a new buffer |
| in_pre | input | 1 | Preamble requested for the buffer (used with in_first) |
| in_ready | output | 1 | Offered byte is taken at this clock edge |
| tx_line | output | 1 | Serial output, idles high |
| busy | output | 1 | A frame or preamble is on the line |

## Verification
The embedded properties check on every cycle that the line moves only on baud edges, that an accepted byte is followed by a low start bit, that a preamble load is followed by a high line, that the handshake happens only on a baud tick, and that no frame is cut short. The exact bit order, the parity values, the preamble length for each format, the absence of a preamble for bytes that are not first, and the seamless joining of frames are only visible in the bench's bit streams. The bench sweeps every format combination and compares each stream against streams it builds from the frame rules.

// File: rtl/uart_pre_pkg.sv
// Shared sizes and the format record for the preamble-capable transmitter.
// Assumes data lengths from DATA_MIN to DATA_MIN + 2**CODE_W - 1.
package uart_pre_pkg;
    localparam int DATA_MIN  = 5;
    localparam int CODE_W    = 2;
    localparam int DATA_MAX  = DATA_MIN + (1 << CODE_W) - 1;
    localparam int FRAME_MAX = 1 + DATA_MAX + 1 + 2;
    localparam int CNT_W     = $clog2(FRAME_MAX + 1);

    typedef struct packed {
        logic [CODE_W-1:0] len_code;
        logic              par_en;
        logic              par_odd;
        logic              stop2;
    } fmt_t;
endpackage

// File: rtl/uart_pre_frame.sv
// Builds one frame image, least significant bit sent first, and its length in
// baud intervals. For a preamble the image is all ones with the same length.
// Purely combinational; assumes the format is stable while a load happens.
module uart_pre_frame
    import uart_pre_pkg::*;
(
    input  fmt_t                 fmt,
    input  logic [DATA_MAX-1:0]  data,
    input  logic                 preamble,
    output logic [FRAME_MAX-1:0] frame,
    output logic [CNT_W-1:0]     len
);
    logic [CNT_W-1:0]     nbits;
    logic [DATA_MAX-1:0]  mask;
    logic                 par_bit;
    logic [FRAME_MAX-1:0] char_bits;

    assign nbits = CNT_W'(DATA_MIN) + CNT_W'(fmt.len_code);

    // One mask bit per data position, set when that position is in use.
    for (genvar gi = 0; gi < DATA_MAX; gi++) begin : g_mask
        assign mask[gi] = (CNT_W'(gi) < nbits);
    end

    // Parity over the used data bits only; odd sense inverts it.
    assign par_bit = (^(data & mask)) ^ fmt.par_odd;

    // Place start bit, data bits and optional parity; the rest stay ones (stop).
    always_comb begin
        char_bits    = '1;
        char_bits[0] = 1'b0;
        for (int i = 0; i < DATA_MAX; i++) begin
            if (mask[i]) char_bits[1 + i] = data[i];
        end
        if (fmt.par_en) char_bits[CNT_W'(1) + nbits] = par_bit;
    end

    // Start + data + parity + stop bits.
    assign len   = CNT_W'(2) + nbits + CNT_W'(fmt.par_en) + CNT_W'(fmt.stop2);
    assign frame = preamble ? '1 : char_bits;
endmodule

// File: rtl/uart_pre_shift.sv
// Shift register and bit counter that put a loaded frame on the line, one bit
// per baud tick. A frame cannot be cancelled once loaded. Assumes the
// controller loads only when idle or during the last bit of a frame.
module uart_pre_shift
    import uart_pre_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 load,
    input  logic [FRAME_MAX-1:0] load_frame,
    input  logic [CNT_W-1:0]     load_len,
    output logic                 line,
    output logic                 active,
    output logic                 last
);
    logic [FRAME_MAX-1:0] sh_q;
    logic [CNT_W-1:0]     cnt_q;

    // Load a new frame, advance one bit, or fall idle, all on baud ticks only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '1;
            cnt_q  <= '0;
            active <= 1'b0;
        end else if (tick) begin
            if (load) begin
                sh_q   <= load_frame;
                cnt_q  <= load_len;
                active <= 1'b1;
            end else if (active) begin
                if (cnt_q == CNT_W'(1)) begin
                    sh_q   <= '1;
                    cnt_q  <= '0;
                    active <= 1'b0;
                end else begin
                    sh_q  <= {1'b1, sh_q[FRAME_MAX-1:1]};
                    cnt_q <= cnt_q - CNT_W'(1);
                end
            end
        end
    end

    assign last = active && (cnt_q == CNT_W'(1));
    assign line = active ? sh_q[0] : 1'b1;

    // R4: the remaining-bit count never exceeds the longest frame.
    a_r4_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(FRAME_MAX));

    // R10: a frame that is not in its last bit is still running one cycle later.
    a_r10_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !last) |=> active);

    // R10: a load never lands in the middle of a frame.
    a_r10_load_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (load && tick) |-> (!active || last));
endmodule

// File: rtl/uart_pre_ctrl.sv
// Decides at each load slot whether to start a preamble or a character, and
// handles the byte handshake. Assumes the source holds a byte and its flags
// stable until in_ready takes it.
module uart_pre_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic active,
    input  logic last,
    input  logic in_valid,
    input  logic in_first,
    input  logic in_pre,
    output logic in_ready,
    output logic load,
    output logic sel_pre
);
    logic pre_done_q;
    logic slot;

    assign slot     = tick && (!active || last);
    assign sel_pre  = in_valid && in_first && in_pre && !pre_done_q;
    assign load     = slot && in_valid;
    assign in_ready = slot && !sel_pre;

    // Remember that the waiting byte's preamble is out; forget it once taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_done_q <= 1'b0;
        end else if (in_valid && in_ready) begin
            pre_done_q <= 1'b0;
        end else if (load && sel_pre) begin
            pre_done_q <= 1'b1;
        end
    end

    // R5: after a preamble is loaded the same byte is taken at the next slot.
    a_r5_one_preamble: assert property (@(posedge clk) disable iff (!rst_n)
        (load && sel_pre) |=> !sel_pre);
endmodule

// File: rtl/uart_pre_tx.sv
// Top of the preamble-capable serial transmitter. Joins the frame builder,
// the load controller and the shifter. Assumes baud_tick is one cycle wide
// and the format inputs change only while busy is low.
module uart_pre_tx
    import uart_pre_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                baud_tick,
    input  logic [CODE_W-1:0]   cfg_len_code,
    input  logic                cfg_par_en,
    input  logic                cfg_par_odd,
    input  logic                cfg_stop2,
    input  logic                in_valid,
    input  logic [DATA_MAX-1:0] in_data,
    input  logic                in_first,
    input  logic                in_pre,
    output logic                in_ready,
    output logic                tx_line,
    output logic                busy
);
    fmt_t                 fmt;
    logic [FRAME_MAX-1:0] frame;
    logic [CNT_W-1:0]     len;
    logic                 load;
    logic                 sel_pre;
    logic                 active;
    logic                 last;

    assign fmt = '{len_code: cfg_len_code, par_en: cfg_par_en,
                   par_odd: cfg_par_odd, stop2: cfg_stop2};

    uart_pre_frame u_frame (
        .fmt      (fmt),
        .data     (in_data),
        .preamble (sel_pre),
        .frame    (frame),
        .len      (len)
    );

    uart_pre_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (baud_tick),
        .active   (active),
        .last     (last),
        .in_valid (in_valid),
        .in_first (in_first),
        .in_pre   (in_pre),
        .in_ready (in_ready),
        .load     (load),
        .sel_pre  (sel_pre)
    );

    uart_pre_shift u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (baud_tick),
        .load       (load),
        .load_frame (frame),
        .load_len   (len),
        .line       (tx_line),
        .active     (active),
        .last       (last)
    );

    assign busy = active;

    // R9: without a baud tick the line holds its value.
    a_r9_line_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !baud_tick |=> $stable(tx_line));

    // R2: a taken byte puts the low start bit on the line next cycle.
    a_r2_start_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !tx_line);

    // R5: a preamble load keeps the line high.
    a_r5_pre_high: assert property (@(posedge clk) disable iff (!rst_n)
        (load && sel_pre) |=> (tx_line && busy));

    // R10: the handshake only completes on a baud tick.
    a_r10_ready_tick: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> baud_tick);
endmodule

// File: tb/uart_pre_tx_bench.sv
// Sweeps every format: each run sends a two-byte buffer with a preamble
// request, then a one-byte buffer without, and compares the bit stream.
module uart_pre_tx_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       baud_tick;
    logic [1:0] cfg_len_code;
    logic       cfg_par_en, cfg_par_odd, cfg_stop2;
    logic       in_valid;
    logic [7:0] in_data;
    logic       in_first, in_pre;
    logic       in_ready, tx_line, busy;

    int n_checks = 0;
    int n_fail   = 0;
    bit got_q[$];
    bit exp_q[$];
    int r9_bad, r10_bad;

    uart_pre_tx u_uart_pre_tx (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
        .cfg_len_code(cfg_len_code), .cfg_par_en(cfg_par_en),
        .cfg_par_odd(cfg_par_odd), .cfg_stop2(cfg_stop2),
        .in_valid(in_valid), .in_data(in_data), .in_first(in_first),
        .in_pre(in_pre), .in_ready(in_ready), .tx_line(tx_line), .busy(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Baud strobe: high for one cycle out of TICK_DIV, changed at negedge.
    initial begin
        baud_tick = 1'b0;
        forever begin
            repeat (TICK_DIV - 1) @(negedge clk);
            baud_tick = 1'b1;
            @(negedge clk);
            baud_tick = 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push_frame(input logic [7:0] d, input int n, input int pe,
                              input int po, input int ts);
        int ones = 0;
        exp_q.push_back(1'b0);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(d[i]);
            ones += d[i];
        end
        if (pe != 0) exp_q.push_back(((ones % 2) != 0) ^ (po != 0));
        for (int i = 0; i < 1 + ts; i++) exp_q.push_back(1'b1);
    endtask

    function automatic int seg(input bit q[$], input int start, input int len);
        int v = 0;
        for (int i = 0; i < len; i++)
            if (start + i < q.size()) v |= int'(q[start + i]) << i;
            else v |= 1 << (i + 16);
        return v;
    endfunction

    task automatic drive(input logic [7:0] d [3]);
        bit f [3] = '{1'b1, 1'b0, 1'b1};
        bit p [3] = '{1'b1, 1'b1, 1'b0};
        for (int k = 0; k < 3; k++) begin
            in_valid = 1'b1; in_data = d[k]; in_first = f[k]; in_pre = p[k];
            #1;
            while (!in_ready) begin
                @(negedge clk); #1;
            end
            if (!baud_tick) r10_bad++;
            @(negedge clk);
        end
        in_valid = 1'b0; in_first = 1'b0; in_pre = 1'b0;
    endtask

    task automatic monitor();
        bit started = 0, done = 0, prev, last_bit = 1'b1;
        int ticks = 0;
        #2;
        prev = baud_tick;
        while (!done && ticks < 400) begin
            @(negedge clk); #2;
            if (prev) begin
                ticks++;
                if (busy) begin
                    started = 1;
                    got_q.push_back(tx_line);
                    last_bit = tx_line;
                end else if (started) done = 1;
            end else if (started && busy && tx_line != last_bit) begin
                r9_bad++;
            end
            prev = baud_tick;
        end
    endtask

    task automatic run_cfg(input int code, input int pe, input int po, input int ts);
        int n = 5 + code;
        int len = 1 + n + pe + 1 + ts;
        logic [7:0] d [3];
        int pidx, pexp, ones;
        d[0] = 8'hA5 ^ 8'(code * 37 + pe * 11 + po * 5 + ts * 3);
        d[1] = 8'h3C ^ 8'(code * 19 + ts * 7);
        d[2] = 8'hD2 ^ 8'(code * 53 + pe * 29);
        got_q.delete(); exp_q.delete();
        r9_bad = 0; r10_bad = 0;
        @(negedge clk);
        cfg_len_code = 2'(code); cfg_par_en = pe[0]; cfg_par_odd = po[0]; cfg_stop2 = ts[0];
        for (int i = 0; i < len; i++) exp_q.push_back(1'b1);
        for (int k = 0; k < 3; k++) push_frame(d[k], n, pe, po, ts);
        fork
            drive(d);
            monitor();
        join
        // R4/R7: whole run is one unbroken busy stretch of the right length.
        check(got_q.size() == 4 * len, "R4/R7 total ticks", got_q.size(), 4 * len);
        // R5: preamble of ones as long as one frame.
        check(seg(got_q, 0, len) == seg(exp_q, 0, len), "R5 preamble",
              seg(got_q, 0, len), seg(exp_q, 0, len));
        // R2: first character shape.
        check(seg(got_q, len, len) == seg(exp_q, len, len), "R2 frame",
              seg(got_q, len, len), seg(exp_q, len, len));
        // R6/R7: second byte (not first, preamble flag set) follows with no preamble.
        check(seg(got_q, 2 * len, len) == seg(exp_q, 2 * len, len), "R6 not-first",
              seg(got_q, 2 * len, len), seg(exp_q, 2 * len, len));
        // R6/R7: new buffer without preamble starts right after the stop bit.
        check(seg(got_q, 3 * len, len) == seg(exp_q, 3 * len, len), "R6 no-pre buffer",
              seg(got_q, 3 * len, len), seg(exp_q, 3 * len, len));
        if (pe != 0) begin
            // R3: parity bit value computed from the data bits.
            ones = 0;
            for (int i = 0; i < n; i++) ones += d[0][i];
            pexp = ((ones % 2) != 0) ^ (po != 0);
            pidx = len + 1 + n;
            check(pidx < got_q.size() && got_q[pidx] == pexp[0], "R3 parity",
                  pidx < got_q.size() ? int'(got_q[pidx]) : -1, pexp);
        end
        check(r9_bad == 0, "R9 mid-bit change", r9_bad, 0);
        check(r10_bad == 0, "R10 ready off tick", r10_bad, 0);
        // R8: idle afterwards.
        repeat (3 * TICK_DIV) @(negedge clk);
        #2;
        check(tx_line == 1'b1 && busy == 1'b0, "R8 idle",
              {tx_line, busy}, 2'b10);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_first = 1'b0; in_pre = 1'b0;
        cfg_len_code = 2'd3; cfg_par_en = 1'b0; cfg_par_odd = 1'b0; cfg_stop2 = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        #2;
        check(tx_line == 1'b1 && busy == 1'b0, "R1 reset", {tx_line, busy}, 2'b10);
        for (int code = 0; code < 4; code++)
            for (int pe = 0; pe < 2; pe++)
                for (int po = 0; po < 2; po++)
                    for (int ts = 0; ts < 2; ts++)
                        if (pe != 0 || po == 0) run_cfg(code, pe, po, ts);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule